// File: doc/BRIEF.md
# Branch Target and Condition Unit

This block chooses the next program counter for the branch instructions of a 64-bit core. Each cycle it takes the current program counter, a branch kind, two PC-relative offset fields of different widths (26 bits for the unconditional immediate form, 19 bits for the conditional form), a register value for the indirect form, a 4-bit condition code and the four arithmetic flags. One clock edge later it presents the chosen target, a taken indication and a flag that marks an unknown condition code.

Offsets count instructions, so the block sign-extends each field and scales it by the instruction size before adding it to the program counter. All arithmetic wraps modulo 2^64. The condition evaluator covers the equality, signed-comparison and always-true codes. Any other code is reported as illegal and the branch then falls through. The pipeline stage that owns the program counter uses the result. Fetch, prediction and link-register writes belong to other blocks.

Top module: `bcu_branch_unit`

## Requirements
- R1: With kind 2'b00 (unconditional immediate), the next PC is pc + sign_extend(off26) * 4 and taken is 1.
- R2: With kind 2'b01 (register-indirect), the next PC equals the register value and taken is 1.
- R3: With kind 2'b10 (conditional), the next PC is pc + sign_extend(off19) * 4 with taken 1 when the condition holds, and pc + 4 with taken 0 otherwise.
- R4: Code 4'b0000 (equal) holds when Z is 1, and code 4'b0001 (not equal) holds when Z is 0.
- R5: Code 4'b1010 (signed greater-or-equal) holds when N equals V, and code 4'b1011 (signed less-than) holds when N differs from V.
- R6: Code 4'b1100 (signed greater-than) holds when Z is 0 and N equals V, and code 4'b1101 (signed less-or-equal) holds when Z is 1 or N differs from V.
- R7: Code 4'b1110 (always) holds for every flag value.
- R8: With kind 2'b10 and any code other than the seven listed in R4 to R7, illegal is 1, taken is 0 and the next PC is pc + 4.
- R9: The carry flag never affects the result. For kinds 2'b00, 2'b01 and 2'b11, the condition code and the flags do not affect the outputs, and illegal stays 0.
- R10: With kind 2'b11 (not a branch), the next PC is pc + 4, taken is 0 and illegal is 0.
- R11: The outputs are registered. They show the result for the inputs present at the previous rising clock edge. While rst is high they are next PC = 0, taken 0 and illegal 0.
- R12: All target sums wrap modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pc_i | input | 64 | Current program counter |
| kind_i | input | 2 | Branch kind: 00 immediate, 01 register, 10 conditional, 11 none |
| off26_i | input | 26 | Signed instruction offset for the unconditional immediate kind |
| off19_i | input | 19 | Signed instruction offset for the conditional kind |
| reg_val_i | input | 64 | Source register value for the register kind |
| cond_i | input | 4 | Condition code |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag (never used) |
| flag_v_i | input | 1 | Overflow flag |
| next_pc_o | output | 64 | Selected next program counter |
| taken_o | output | 1 | Branch redirects the program counter |
| illegal_o | output | 1 | Unknown condition code on a conditional branch |

## Verification
The condition decoder and the target selection act in every cycle, even when the kind makes the condition irrelevant. A reserved condition code can therefore arrive in the same cycle as an unconditional or register branch. The bench pairs reserved codes and all-ones flags with those kinds and checks that illegal stays low while the target and taken still follow the kind. It also places taken and not-taken branches at the top and bottom of the address space, so that the offset addition and the wraparound happen in the same cycle, and compares the wrapped target with the value computed by hand.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

   typedef enum logic [1:0] {
      BK_IMM  = 2'b00,
      BK_REG  = 2'b01,
      BK_COND = 2'b10,
      BK_SEQ  = 2'b11
   } br_kind_e;

   localparam logic [3:0] CC_EQ = 4'b0000;
   localparam logic [3:0] CC_NE = 4'b0001;
   localparam logic [3:0] CC_GE = 4'b1010;
   localparam logic [3:0] CC_LT = 4'b1011;
   localparam logic [3:0] CC_GT = 4'b1100;
   localparam logic [3:0] CC_LE = 4'b1101;
   localparam logic [3:0] CC_AL = 4'b1110;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } nzcv_t;

endpackage

// File: rtl/bcu_offset_scale.sv
module bcu_offset_scale #(
   parameter int FIELD_W    = 26,
   parameter int OUT_W      = 64,
   parameter int SCALE_LOG2 = 2
) (
   input  logic [FIELD_W-1:0] field_i,
   output logic [OUT_W-1:0]   byte_off_o
);
   localparam int SPAN_W = FIELD_W + SCALE_LOG2;

   if (FIELD_W < 1) begin : g_bad_field
      $error("bcu_offset_scale: FIELD_W must be at least 1");
   end
   if (SPAN_W > OUT_W) begin : g_bad_span
      $error("bcu_offset_scale: scaled field does not fit OUT_W");
   end

   logic signed [OUT_W-1:0] widened;

   // sign-extend first, then scale by the instruction size
   assign widened    = OUT_W'($signed(field_i));
   assign byte_off_o = widened << SCALE_LOG2;

endmodule

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
   import bcu_pkg::*;
(
   input  logic [3:0] cond_i,
   input  nzcv_t      flags_i,
   output logic       holds_o,
   output logic       legal_o
);
   logic unused_carry;
   logic n_eq_v;

   // carry plays no part in any supported condition
   assign unused_carry = flags_i.c;
   assign n_eq_v       = (flags_i.n == flags_i.v);

   always_comb begin
      legal_o = 1'b1;
      holds_o = 1'b0;
      case (cond_i)
         CC_EQ:   holds_o = flags_i.z;
         CC_NE:   holds_o = !flags_i.z;
         CC_GE:   holds_o = n_eq_v;
         CC_LT:   holds_o = !n_eq_v;
         CC_GT:   holds_o = !flags_i.z && n_eq_v;
         CC_LE:   holds_o = flags_i.z || !n_eq_v;
         CC_AL:   holds_o = 1'b1;
         default: legal_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/bcu_target_sel.sv
module bcu_target_sel
   import bcu_pkg::*;
#(
   parameter int PC_W       = 64,
   parameter int STEP_LOG2  = 2,
   parameter bit SHARED_ADD = 1'b1
) (
   input  br_kind_e         kind_i,
   input  logic [PC_W-1:0]  pc_i,
   input  logic [PC_W-1:0]  reg_val_i,
   input  logic [PC_W-1:0]  imm_off_i,
   input  logic [PC_W-1:0]  cond_off_i,
   input  logic             holds_i,
   input  logic             legal_i,
   output logic [PC_W-1:0]  next_pc_o,
   output logic             taken_o,
   output logic             illegal_o
);
   localparam logic [PC_W-1:0] STEP = PC_W'(1) << STEP_LOG2;

   logic cond_go;

   assign cond_go   = (kind_i == BK_COND) && holds_i && legal_i;
   assign illegal_o = (kind_i == BK_COND) && !legal_i;
   assign taken_o   = (kind_i == BK_IMM) || (kind_i == BK_REG) || cond_go;

   if (SHARED_ADD) begin : g_shared
      // one adder, the addend picked ahead of it
      logic [PC_W-1:0] addend;
      logic [PC_W-1:0] sum;
      always_comb begin
         addend = STEP;
         if (kind_i == BK_IMM)
            addend = imm_off_i;
         else if (cond_go)
            addend = cond_off_i;
      end
      assign sum       = pc_i + addend;
      assign next_pc_o = (kind_i == BK_REG) ? reg_val_i : sum;
   end else begin : g_parallel
      // three adders in parallel, selection after them
      logic [PC_W-1:0] sum_imm;
      logic [PC_W-1:0] sum_cond;
      logic [PC_W-1:0] sum_seq;
      assign sum_imm  = pc_i + imm_off_i;
      assign sum_cond = pc_i + cond_off_i;
      assign sum_seq  = pc_i + STEP;
      always_comb begin
         case (kind_i)
            BK_IMM:  next_pc_o = sum_imm;
            BK_REG:  next_pc_o = reg_val_i;
            BK_COND: next_pc_o = cond_go ? sum_cond : sum_seq;
            default: next_pc_o = sum_seq;
         endcase
      end
   end

endmodule

// File: rtl/bcu_branch_unit.sv
module bcu_branch_unit
   import bcu_pkg::*;
#(
   parameter int              PC_W       = 64,
   parameter int              UNC_OFF_W  = 26,
   parameter int              CND_OFF_W  = 19,
   parameter int              STEP_LOG2  = 2,
   parameter bit              SHARED_ADD = 1'b1,
   parameter logic [PC_W-1:0] RESET_PC   = '0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [PC_W-1:0] pc_i,
   input  logic [1:0]      kind_i,
   input  logic [UNC_OFF_W-1:0] off26_i,
   input  logic [CND_OFF_W-1:0] off19_i,
   input  logic [PC_W-1:0] reg_val_i,
   input  logic [3:0]      cond_i,
   input  logic            flag_n_i,
   input  logic            flag_z_i,
   input  logic            flag_c_i,
   input  logic            flag_v_i,
   output logic [PC_W-1:0] next_pc_o,
   output logic            taken_o,
   output logic            illegal_o
);
   localparam logic [PC_W-1:0] STEP = PC_W'(1) << STEP_LOG2;

   if (PC_W < UNC_OFF_W + STEP_LOG2) begin : g_bad_unc
      $error("bcu_branch_unit: PC_W too narrow for the unconditional offset");
   end
   if (PC_W < CND_OFF_W + STEP_LOG2) begin : g_bad_cnd
      $error("bcu_branch_unit: PC_W too narrow for the conditional offset");
   end

   nzcv_t           flags;
   logic [PC_W-1:0] imm_off;
   logic [PC_W-1:0] cond_off;
   logic            holds;
   logic            legal;
   logic [PC_W-1:0] nxt_d;
   logic            taken_d;
   logic            illegal_d;
   logic            out_live;

   assign flags = '{n: flag_n_i, z: flag_z_i, c: flag_c_i, v: flag_v_i};

   bcu_offset_scale #(
      .FIELD_W(UNC_OFF_W), .OUT_W(PC_W), .SCALE_LOG2(STEP_LOG2)
   ) u_off_unc (
      .field_i(off26_i), .byte_off_o(imm_off)
   );

   bcu_offset_scale #(
      .FIELD_W(CND_OFF_W), .OUT_W(PC_W), .SCALE_LOG2(STEP_LOG2)
   ) u_off_cnd (
      .field_i(off19_i), .byte_off_o(cond_off)
   );

   bcu_cond_eval u_cond (
      .cond_i(cond_i), .flags_i(flags), .holds_o(holds), .legal_o(legal)
   );

   bcu_target_sel #(
      .PC_W(PC_W), .STEP_LOG2(STEP_LOG2), .SHARED_ADD(SHARED_ADD)
   ) u_sel (
      .kind_i(br_kind_e'(kind_i)),
      .pc_i(pc_i),
      .reg_val_i(reg_val_i),
      .imm_off_i(imm_off),
      .cond_off_i(cond_off),
      .holds_i(holds),
      .legal_i(legal),
      .next_pc_o(nxt_d),
      .taken_o(taken_d),
      .illegal_o(illegal_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         next_pc_o <= RESET_PC;
         taken_o   <= 1'b0;
         illegal_o <= 1'b0;
         out_live  <= 1'b0;
      end else begin
         next_pc_o <= nxt_d;
         taken_o   <= taken_d;
         illegal_o <= illegal_d;
         out_live  <= 1'b1;
      end
   end

   // R11: outputs hold reset values until the first edge after reset
   assert_reset_state_R11: assert property (@(posedge clk) disable iff (rst)
      !out_live |-> (next_pc_o == RESET_PC && !taken_o && !illegal_o));

   // R8: an unknown condition never redirects
   assert_illegal_not_taken_R8: assert property (@(posedge clk) disable iff (rst)
      illegal_o |-> !taken_o);

   // R2: register branch copies the register value one cycle later
   assert_reg_target_R2: assert property (@(posedge clk) disable iff (rst)
      (out_live && $past(kind_i) == BK_REG) |->
      (next_pc_o == $past(reg_val_i) && taken_o && !illegal_o));

   // R1: unconditional immediate branch is always taken
   assert_imm_taken_R1: assert property (@(posedge clk) disable iff (rst)
      (out_live && $past(kind_i) == BK_IMM) |-> (taken_o && !illegal_o));

   // R3: a conditional branch that is not taken falls through
   assert_fallthrough_R3: assert property (@(posedge clk) disable iff (rst)
      (out_live && $past(kind_i) == BK_COND && !taken_o) |->
      (next_pc_o == $past(pc_i) + STEP));

   // R4: equal code follows the zero flag
   assert_eq_follows_z_R4: assert property (@(posedge clk) disable iff (rst)
      (out_live && $past(kind_i == BK_COND && cond_i == CC_EQ)) |->
      (taken_o == $past(flag_z_i)));

   // R7: always code is always taken
   assert_al_taken_R7: assert property (@(posedge clk) disable iff (rst)
      (out_live && $past(kind_i == BK_COND && cond_i == CC_AL)) |-> taken_o);

   // R10: non-branch kind steps sequentially
   assert_seq_kind_R10: assert property (@(posedge clk) disable iff (rst)
      (out_live && $past(kind_i) == BK_SEQ) |->
      (!taken_o && !illegal_o && next_pc_o == $past(pc_i) + STEP));

endmodule

// File: tb/tb_bcu_branch_unit.sv
`timescale 1ns/1ps
module tb_bcu_branch_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [63:0] pc_i = '0;
   logic [1:0]  kind_i = 2'b11;
   logic [25:0] off26_i = '0;
   logic [18:0] off19_i = '0;
   logic [63:0] reg_val_i = '0;
   logic [3:0]  cond_i = '0;
   logic        flag_n_i = 1'b0;
   logic        flag_z_i = 1'b0;
   logic        flag_c_i = 1'b0;
   logic        flag_v_i = 1'b0;
   logic [63:0] next_pc_o;
   logic        taken_o;
   logic        illegal_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   bcu_branch_unit dut (
      .clk(clk), .rst(rst), .pc_i(pc_i), .kind_i(kind_i),
      .off26_i(off26_i), .off19_i(off19_i), .reg_val_i(reg_val_i),
      .cond_i(cond_i), .flag_n_i(flag_n_i), .flag_z_i(flag_z_i),
      .flag_c_i(flag_c_i), .flag_v_i(flag_v_i),
      .next_pc_o(next_pc_o), .taken_o(taken_o), .illegal_o(illegal_o)
   );

   // nzcv packs the flags as {N, Z, C, V}
   typedef struct packed {
      logic [1:0]  kind;
      logic [3:0]  cond;
      logic [3:0]  nzcv;
      logic [25:0] o26;
      logic [18:0] o19;
      logic [63:0] pc;
      logic [63:0] rv;
      logic [63:0] epc;
      logic        et;
      logic        ei;
      logic [3:0]  req;
   } vec_t;

   localparam logic [63:0] B = 64'h1000;
   localparam int NV = 29;
   localparam vec_t VECS [NV] = '{
      '{2'b00, 4'h0, 4'b0000, 26'h0000010, 19'h0, B, 64'h0, 64'h1040, 1'b1, 1'b0, 4'd1},   // R1
      '{2'b00, 4'h0, 4'b0000, 26'h3FFFFFF, 19'h0, B, 64'h0, 64'h0FFC, 1'b1, 1'b0, 4'd1},   // R1
      '{2'b00, 4'h0, 4'b0000, 26'h2000000, 19'h0, B, 64'h0, 64'hFFFF_FFFF_F800_1000, 1'b1, 1'b0, 4'd1}, // R1
      '{2'b01, 4'h7, 4'b1111, 26'h0, 19'h0, B, 64'hDEAD_BEEF_0000_0010, 64'hDEAD_BEEF_0000_0010, 1'b1, 1'b0, 4'd2}, // R2
      '{2'b10, 4'h0, 4'b0100, 26'h0, 19'h00008, B, 64'h0, 64'h1020, 1'b1, 1'b0, 4'd4},    // R4
      '{2'b10, 4'h0, 4'b1011, 26'h0, 19'h00008, B, 64'h0, 64'h1004, 1'b0, 1'b0, 4'd4},    // R4
      '{2'b10, 4'h1, 4'b0000, 26'h0, 19'h7FFFF, B, 64'h0, 64'h0FFC, 1'b1, 1'b0, 4'd4},    // R4
      '{2'b10, 4'h1, 4'b0100, 26'h0, 19'h00008, B, 64'h0, 64'h1004, 1'b0, 1'b0, 4'd4},    // R4
      '{2'b10, 4'hA, 4'b1001, 26'h0, 19'h40000, B, 64'h0, 64'hFFFF_FFFF_FFF0_1000, 1'b1, 1'b0, 4'd5}, // R5
      '{2'b10, 4'hA, 4'b1000, 26'h0, 19'h00008, B, 64'h0, 64'h1004, 1'b0, 1'b0, 4'd5},    // R5
      '{2'b10, 4'hB, 4'b0001, 26'h0, 19'h00008, B, 64'h0, 64'h1020, 1'b1, 1'b0, 4'd5},    // R5
      '{2'b10, 4'hB, 4'b1001, 26'h0, 19'h00008, B, 64'h0, 64'h1004, 1'b0, 1'b0, 4'd5},    // R5
      '{2'b10, 4'hC, 4'b0000, 26'h0, 19'h00008, B, 64'h0, 64'h1020, 1'b1, 1'b0, 4'd6},    // R6
      '{2'b10, 4'hC, 4'b0100, 26'h0, 19'h00008, B, 64'h0, 64'h1004, 1'b0, 1'b0, 4'd6},    // R6
      '{2'b10, 4'hC, 4'b1000, 26'h0, 19'h00008, B, 64'h0, 64'h1004, 1'b0, 1'b0, 4'd6},    // R6
      '{2'b10, 4'hD, 4'b0100, 26'h0, 19'h00008, B, 64'h0, 64'h1020, 1'b1, 1'b0, 4'd6},    // R6
      '{2'b10, 4'hD, 4'b1000, 26'h0, 19'h00008, B, 64'h0, 64'h1020, 1'b1, 1'b0, 4'd6},    // R6
      '{2'b10, 4'hD, 4'b0000, 26'h0, 19'h00008, B, 64'h0, 64'h1004, 1'b0, 1'b0, 4'd6},    // R6
      '{2'b10, 4'hE, 4'b0000, 26'h0, 19'h00008, B, 64'h0, 64'h1020, 1'b1, 1'b0, 4'd7},    // R7
      '{2'b10, 4'hE, 4'b1111, 26'h0, 19'h00008, B, 64'h0, 64'h1020, 1'b1, 1'b0, 4'd7},    // R7
      '{2'b10, 4'h2, 4'b0000, 26'h0, 19'h00008, B, 64'h0, 64'h1004, 1'b0, 1'b1, 4'd8},    // R8
      '{2'b10, 4'hF, 4'b0100, 26'h0, 19'h00008, B, 64'h0, 64'h1004, 1'b0, 1'b1, 4'd8},    // R8
      '{2'b11, 4'h3, 4'b1111, 26'h0000010, 19'h00008, B, 64'h0, 64'h1004, 1'b0, 1'b0, 4'd10}, // R10
      '{2'b00, 4'hF, 4'b1111, 26'h0000010, 19'h0, B, 64'h0, 64'h1040, 1'b1, 1'b0, 4'd9},  // R9
      '{2'b10, 4'h0, 4'b0010, 26'h0, 19'h00008, B, 64'h0, 64'h1004, 1'b0, 1'b0, 4'd9},    // R9
      '{2'b10, 4'hA, 4'b0010, 26'h0, 19'h00008, B, 64'h0, 64'h1020, 1'b1, 1'b0, 4'd9},    // R9
      '{2'b10, 4'h1, 4'b0100, 26'h0, 19'h00008, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0, 64'h0, 1'b0, 1'b0, 4'd12}, // R12
      '{2'b00, 4'h0, 4'b0000, 26'h0000008, 19'h0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 64'h10, 1'b1, 1'b0, 4'd12}, // R12
      '{2'b10, 4'hB, 4'b0001, 26'h0, 19'h7FFFF, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFC, 1'b1, 1'b0, 4'd12} // R12
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      @(negedge clk);
      kind_i    = v.kind;
      cond_i    = v.cond;
      {flag_n_i, flag_z_i, flag_c_i, flag_v_i} = v.nzcv;
      off26_i   = v.o26;
      off19_i   = v.o19;
      pc_i      = v.pc;
      reg_val_i = v.rv;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R11 reset next_pc", next_pc_o, 64'h0);
      chk("R11 reset taken", {63'h0, taken_o}, 64'h0);
      chk("R11 reset illegal", {63'h0, illegal_o}, 64'h0);
      @(negedge clk);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         @(posedge clk);
         #1;
         chk($sformatf("R%0d vec %0d next_pc", VECS[i].req, i), next_pc_o, VECS[i].epc);
         chk($sformatf("R%0d vec %0d taken", VECS[i].req, i), {63'h0, taken_o}, {63'h0, VECS[i].et});
         chk($sformatf("R%0d vec %0d illegal", VECS[i].req, i), {63'h0, illegal_o}, {63'h0, VECS[i].ei});
      end

      // R11: new inputs do not reach the outputs before the next edge
      drive(VECS[0]);
      #1;
      chk("R11 latency hold next_pc", next_pc_o, 64'hFFFF_FFFF_FFFF_FFFC);
      @(posedge clk);
      #1;
      chk("R11 latency update next_pc", next_pc_o, 64'h1040);

      // R3: conditional taken then fall-through back to back
      drive(VECS[12]);
      @(posedge clk);
      #1;
      chk("R3 taken target", next_pc_o, 64'h1020);
      drive(VECS[13]);
      @(posedge clk);
      #1;
      chk("R3 fall-through target", next_pc_o, 64'h1004);

      // R11: reset in mid-run clears the outputs
      drive(VECS[20]);
      rst = 1'b1;
      @(posedge clk);
      #1;
      chk("R11 mid-run reset next_pc", next_pc_o, 64'h0);
      chk("R11 mid-run reset illegal", {63'h0, illegal_o}, 64'h0);
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk);
      #1;
      chk("R8 after reset illegal", {63'h0, illegal_o}, 64'h1);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule